// File: doc/BRIEF.md
# Two-Frame Justification Command Codec

This block handles the justification signalling of one tributary in a second-order bit-interleaved multiplexer that uses positive, zero and negative justification. On the transmit side it takes a justification decision at the start of every two-frame command pair. It holds that decision for both frames and emits a 3-bit control word in each frame. It also tells the multiplexer, for the current position in the fourth control set, whether that position should be filled with a tributary data bit.

On the receive side it takes the 3-bit control word of each frame and reduces it to one bit by majority vote. After the second frame of a pair it decodes the two votes into a command, and tells the demultiplexer whether this tributary's negative slot carries data and whether its positive slot holds a dummy bit to drop. An illegal pair is handled as no justification and raises an error flag for one frame.

Frame alignment, buffer fill measurement and the rest of the frame layout belong to the surrounding multiplexer. This block sees only a frame pulse, the word strobes, the pair-position flag and the index of the current bit within the fourth control set.

Top module: `jcc_codec`

## Requirements
- R1: The decision input is coded 2'b00 none, 2'b01 positive, 2'b10 negative; 2'b11 counts as none. In the first frame of a pair, tx_word is 111 for positive or none and 000 for negative. In the second frame, tx_word is 111 for positive and 000 for negative or none.
- R2: The decision is sampled only on a frame_tick that starts a pair, and the first frame_tick after reset starts a pair. A decision present at any other time has no effect on tx_word or on the slot flags.
- R3: tx_neg_data is high for the whole second frame of a negative pair, and tx_pos_dummy for the whole second frame of a positive pair. Both are low at all other times.
- R4: Each received word is reduced to 1 when at least two of its three bits are 1, and to 0 otherwise, so a single bit error per word is tolerated.
- R5: A strobe with rx_first high stores the vote and clears the receive outputs. A strobe with rx_first low decodes the pair as (1,1) positive, (0,0) negative, (1,0) none. The results appear on the cycle after the strobe and hold until the next strobe.
- R6: The vote pair (0,1) is decoded as none (rx_cmd 2'b00) with rx_err high until the next strobe.
- R7: A second-frame strobe with no first-frame strobe since the last decode gives none with rx_err high.
- R8: With tributary number TRIB (1 to 4), the negative slot is bit 4+TRIB of the fourth control set and the positive slot is bit 8+TRIB; a set-bit value of 0 means outside the set. tx_take_data is high at the negative slot when tx_neg_data is high, and at the positive slot when tx_pos_dummy is low.
- R9: rx_keep_data is high at the negative slot when rx_neg_data is high, and at the positive slot when rx_pos_drop is low. rx_neg_data is high for a negative command and rx_pos_drop for a positive command.
- R10: After reset, tx_word is 000, all flags are low and rx_cmd is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse at the start of each transmit frame |
| tx_decision | input | 2 | Justification decision for the next pair |
| tx_word | output | 3 | Control word for the current frame |
| tx_neg_data | output | 1 | Negative slot carries tributary data this frame |
| tx_pos_dummy | output | 1 | Positive slot carries a dummy bit this frame |
| tx_set_bit | input | 4 | Current transmit bit index in the fourth control set, 0 outside |
| tx_take_data | output | 1 | Current transmit position takes a tributary bit |
| rx_strobe | input | 1 | A received control word is present |
| rx_first | input | 1 | The strobed word belongs to the first frame of a pair |
| rx_word | input | 3 | Received control word |
| rx_cmd | output | 2 | Decoded command, coded as tx_decision |
| rx_neg_data | output | 1 | Receive negative slot holds data |
| rx_pos_drop | output | 1 | Receive positive slot holds a dummy bit to drop |
| rx_err | output | 1 | Illegal or orphan pair decoded |
| rx_set_bit | input | 4 | Current receive bit index in the fourth control set, 0 outside |
| rx_keep_data | output | 1 | Current receive position delivers a tributary bit |

## Verification
tx_word and the transmit flags change on the clock edge that samples frame_tick. The receive command, flags and error change on the edge that samples rx_strobe. The two slot outputs follow the set-bit inputs without delay. The bench drives every input one nanosecond after a rising edge and samples one nanosecond after the next rising edge. Its reference model is updated for exactly the edge in between, so each result is compared in the first cycle it is due and in every later cycle it must hold.

// File: rtl/jcc_pkg.sv
// Shared types for the justification command codec.
package jcc_pkg;

    typedef enum logic [1:0] {
        JC_NONE = 2'b00,
        JC_POS  = 2'b01,
        JC_NEG  = 2'b10
    } jc_cmd_t;

    // Map a raw decision code to a command; the unused code counts as none.
    function automatic jc_cmd_t jc_norm(input logic [1:0] code);
        case (code)
            2'b01:   return JC_POS;
            2'b10:   return JC_NEG;
            default: return JC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/jcc_tx_encoder.sv
// Transmit side: samples a decision at the start of each two-frame pair,
// holds it for both frames and produces the per-frame control word and
// the slot-content flags. Assumes frame_tick is a single-cycle pulse.
module jcc_tx_encoder
    import jcc_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_tick,
    input  logic [1:0]    tx_decision,
    output logic [CW-1:0] tx_word,
    output logic          tx_neg_data,
    output logic          tx_pos_dummy
);

    localparam logic [CW-1:0] ONES  = {CW{1'b1}};
    localparam logic [CW-1:0] ZEROS = {CW{1'b0}};

    logic    second_q; // 1: current frame is the second of a pair (or idle after reset)
    jc_cmd_t cmd_q;

    // Advance the pair phase on every frame and latch the decision at pair start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_q <= 1'b1;
            cmd_q    <= JC_NONE;
        end else if (frame_tick) begin
            second_q <= ~second_q;
            if (second_q) cmd_q <= jc_norm(tx_decision);
        end
    end

    // Form the control word from the held command and pair phase.
    always_comb begin
        if (!second_q) tx_word = (cmd_q == JC_NEG) ? ZEROS : ONES;
        else           tx_word = (cmd_q == JC_POS) ? ONES  : ZEROS;
    end

    // Justification takes effect in the second frame of the pair.
    assign tx_neg_data  = second_q && (cmd_q == JC_NEG);
    assign tx_pos_dummy = second_q && (cmd_q == JC_POS);

    // Command must not change on the tick that opens the second frame.
    assert_pair_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !second_q) |=> (cmd_q == $past(cmd_q)));

    // The first-frame word reflects the decision sampled at pair start.
    assert_first_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && second_q) |=>
        (tx_word == ((jc_norm($past(tx_decision)) == JC_NEG) ? ZEROS : ONES)));

    // Only one slot can be altered in a frame.
    assert_flag_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_neg_data && tx_pos_dummy));

endmodule

// File: rtl/jcc_rx_decoder.sv
// Receive side: majority-votes each control word, pairs the votes of two
// frames and decodes the command. Assumes the frame aligner marks which
// strobed word opens a pair.
module jcc_rx_decoder
    import jcc_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_strobe,
    input  logic          rx_first,
    input  logic [CW-1:0] rx_word,
    output logic [1:0]    rx_cmd,
    output logic          rx_neg_data,
    output logic          rx_pos_drop,
    output logic          rx_err
);

    localparam int CNT_W = $clog2(CW + 1);
    localparam int HALF  = CW / 2;

    logic [CNT_W-1:0] ones_cnt;
    logic             vote;
    logic             have_first_q;
    logic             first_vote_q;
    jc_cmd_t          cmd_q;
    logic             err_q;

    // Count ones in the received word for the majority vote.
    always_comb begin
        ones_cnt = '0;
        for (int i = 0; i < CW; i++) ones_cnt = ones_cnt + CNT_W'(rx_word[i]);
    end

    assign vote = (int'(ones_cnt) > HALF);

    // Store the first vote, then decode the pair on the second strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_first_q <= 1'b0;
            first_vote_q <= 1'b0;
            cmd_q        <= JC_NONE;
            err_q        <= 1'b0;
        end else if (rx_strobe) begin
            if (rx_first) begin
                have_first_q <= 1'b1;
                first_vote_q <= vote;
                cmd_q        <= JC_NONE;
                err_q        <= 1'b0;
            end else begin
                have_first_q <= 1'b0;
                if (!have_first_q) begin
                    cmd_q <= JC_NONE;
                    err_q <= 1'b1;
                end else begin
                    case ({first_vote_q, vote})
                        2'b11:   begin cmd_q <= JC_POS;  err_q <= 1'b0; end
                        2'b00:   begin cmd_q <= JC_NEG;  err_q <= 1'b0; end
                        2'b10:   begin cmd_q <= JC_NONE; err_q <= 1'b0; end
                        default: begin cmd_q <= JC_NONE; err_q <= 1'b1; end
                    endcase
                end
            end
        end
    end

    assign rx_cmd      = cmd_q;
    assign rx_neg_data = (cmd_q == JC_NEG);
    assign rx_pos_drop = (cmd_q == JC_POS);
    assign rx_err      = err_q;

    // A first-frame strobe clears the previous result.
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && rx_first) |=> (!rx_err && (rx_cmd == JC_NONE)));

    // Results hold between strobes.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_strobe |=> ($stable(rx_cmd) && $stable(rx_err)));

    // A second word without its first is flagged.
    assert_orphan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && !rx_first && !have_first_q) |=> (rx_err && (rx_cmd == JC_NONE)));

endmodule

// File: rtl/jcc_slot_map.sv
// Locates one tributary's negative and positive justification slots in the
// fourth control set and says whether the current position carries data.
// Assumes set_bit counts 1 upward inside the set and is 0 elsewhere.
module jcc_slot_map #(
    parameter int TRIB = 1,
    parameter int SB_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SB_W-1:0] set_bit,
    input  logic            neg_has_data,
    input  logic            pos_is_dummy,
    output logic            carries_data
);

    localparam logic [SB_W-1:0] NEG_BIT = SB_W'(4 + TRIB);
    localparam logic [SB_W-1:0] POS_BIT = SB_W'(8 + TRIB);

    // Select the slot content rule for the current set position.
    always_comb begin
        if (set_bit == NEG_BIT)      carries_data = neg_has_data;
        else if (set_bit == POS_BIT) carries_data = ~pos_is_dummy;
        else                         carries_data = 1'b0;
    end

    // Data is only ever taken at one of this tributary's two slots.
    assert_slot_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        carries_data |-> ((set_bit == NEG_BIT) || (set_bit == POS_BIT)));

endmodule

// File: rtl/jcc_codec.sv
// Top of the two-frame justification command codec for one tributary:
// transmit encoder, receive decoder and a slot map for each direction.
// Assumes TRIB lies in 1..4 and CW is odd.
module jcc_codec #(
    parameter int CW   = 3,
    parameter int TRIB = 1,
    parameter int SB_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_tick,
    input  logic [1:0]      tx_decision,
    output logic [CW-1:0]   tx_word,
    output logic            tx_neg_data,
    output logic            tx_pos_dummy,
    input  logic [SB_W-1:0] tx_set_bit,
    output logic            tx_take_data,
    input  logic            rx_strobe,
    input  logic            rx_first,
    input  logic [CW-1:0]   rx_word,
    output logic [1:0]      rx_cmd,
    output logic            rx_neg_data,
    output logic            rx_pos_drop,
    output logic            rx_err,
    input  logic [SB_W-1:0] rx_set_bit,
    output logic            rx_keep_data
);

    jcc_tx_encoder #(.CW(CW)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_tick   (frame_tick),
        .tx_decision  (tx_decision),
        .tx_word      (tx_word),
        .tx_neg_data  (tx_neg_data),
        .tx_pos_dummy (tx_pos_dummy)
    );

    jcc_rx_decoder #(.CW(CW)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_strobe   (rx_strobe),
        .rx_first    (rx_first),
        .rx_word     (rx_word),
        .rx_cmd      (rx_cmd),
        .rx_neg_data (rx_neg_data),
        .rx_pos_drop (rx_pos_drop),
        .rx_err      (rx_err)
    );

    jcc_slot_map #(.TRIB(TRIB), .SB_W(SB_W)) u_tx_slots (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_bit      (tx_set_bit),
        .neg_has_data (tx_neg_data),
        .pos_is_dummy (tx_pos_dummy),
        .carries_data (tx_take_data)
    );

    jcc_slot_map #(.TRIB(TRIB), .SB_W(SB_W)) u_rx_slots (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_bit      (rx_set_bit),
        .neg_has_data (rx_neg_data),
        .pos_is_dummy (rx_pos_drop),
        .carries_data (rx_keep_data)
    );

endmodule

// File: tb/jcc_codec_bench.sv
`timescale 1ns/1ps
module jcc_codec_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic [1:0] tx_decision = 2'b00;
    logic [2:0] tx_word;
    logic       tx_neg_data, tx_pos_dummy, tx_take_data;
    logic [3:0] tx_set_bit = 4'd0;
    logic       rx_strobe = 1'b0, rx_first = 1'b0;
    logic [2:0] rx_word = 3'd0;
    logic [1:0] rx_cmd;
    logic       rx_neg_data, rx_pos_drop, rx_err, rx_keep_data;
    logic [3:0] rx_set_bit = 4'd0;

    int checks = 0;
    int errors = 0;

    // Reference model state
    bit   m_second = 1'b1;
    int   m_cmd    = 0;   // 0 none, 1 pos, 2 neg
    bit   m_hf     = 1'b0;
    bit   m_v1     = 1'b0;
    int   m_rcmd   = 0;
    bit   m_rerr   = 1'b0;

    always #2.5 clk = ~clk;

    jcc_codec u_jcc_codec (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .tx_decision(tx_decision),
        .tx_word(tx_word), .tx_neg_data(tx_neg_data), .tx_pos_dummy(tx_pos_dummy),
        .tx_set_bit(tx_set_bit), .tx_take_data(tx_take_data),
        .rx_strobe(rx_strobe), .rx_first(rx_first), .rx_word(rx_word),
        .rx_cmd(rx_cmd), .rx_neg_data(rx_neg_data), .rx_pos_drop(rx_pos_drop),
        .rx_err(rx_err), .rx_set_bit(rx_set_bit), .rx_keep_data(rx_keep_data)
    );

    function automatic int norm(input logic [1:0] d);
        return (d == 2'b01) ? 1 : (d == 2'b10) ? 2 : 0;
    endfunction

    function automatic bit maj(input logic [2:0] w);
        return (int'(w[0]) + int'(w[1]) + int'(w[2])) >= 2;
    endfunction

    function automatic int exp_word();
        if (!m_second) return (m_cmd == 2) ? 0 : 7;
        return (m_cmd == 1) ? 7 : 0;
    endfunction

    function automatic bit slot(input int sb, input bit negd, input bit posd);
        if (sb == 5) return negd;
        if (sb == 9) return !posd;
        return 1'b0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model for the edge just taken.
    task automatic model_edge();
        if (!rst_n) begin
            m_second = 1'b1; m_cmd = 0; m_hf = 1'b0; m_v1 = 1'b0; m_rcmd = 0; m_rerr = 1'b0;
            return;
        end
        if (frame_tick) begin
            if (m_second) m_cmd = norm(tx_decision);
            m_second = !m_second;
        end
        if (rx_strobe) begin
            if (rx_first) begin
                m_hf = 1'b1; m_v1 = maj(rx_word); m_rcmd = 0; m_rerr = 1'b0;
            end else begin
                if (!m_hf) begin
                    m_rcmd = 0; m_rerr = 1'b1;
                end else begin
                    case ({m_v1, maj(rx_word)})
                        2'b11:   begin m_rcmd = 1; m_rerr = 1'b0; end
                        2'b00:   begin m_rcmd = 2; m_rerr = 1'b0; end
                        2'b10:   begin m_rcmd = 0; m_rerr = 1'b0; end
                        default: begin m_rcmd = 0; m_rerr = 1'b1; end
                    endcase
                end
                m_hf = 1'b0;
            end
        end
    endtask

    // One clock: take the edge, update the model, compare all outputs.
    task automatic step();
        bit en, ed;
        @(posedge clk);
        model_edge();
        #1;
        en = !m_second && 0;
        en = m_second && (m_cmd == 2);
        ed = m_second && (m_cmd == 1);
        chk("R1/R2 tx_word", int'(tx_word), exp_word());
        chk("R3 tx_neg_data", int'(tx_neg_data), int'(en));
        chk("R3 tx_pos_dummy", int'(tx_pos_dummy), int'(ed));
        chk("R8 tx_take_data", int'(tx_take_data), int'(slot(int'(tx_set_bit), en, ed)));
        chk("R5/R4 rx_cmd", int'(rx_cmd), m_rcmd);
        chk("R6/R7 rx_err", int'(rx_err), int'(m_rerr));
        chk("R9 rx_neg_data", int'(rx_neg_data), int'(m_rcmd == 2));
        chk("R9 rx_pos_drop", int'(rx_pos_drop), int'(m_rcmd == 1));
        chk("R9 rx_keep_data", int'(rx_keep_data),
            int'(slot(int'(rx_set_bit), m_rcmd == 2, m_rcmd == 1)));
        frame_tick = 1'b0;
        rx_strobe  = 1'b0;
    endtask

    task automatic tx_frame(input logic [1:0] d, input int idle);
        frame_tick = 1'b1; tx_decision = d;
        step();
        for (int i = 0; i < idle; i++) begin
            tx_decision = ~d;   // changes outside a pair start are ignored (R2)
            step();
        end
    endtask

    task automatic rx_put(input bit first, input logic [2:0] w);
        rx_strobe = 1'b1; rx_first = first; rx_word = w;
        step();
        step();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R10: reset state
        repeat (3) step();
        chk("R10 reset tx_word", int'(tx_word), 0);
        chk("R10 reset rx_cmd", int'(rx_cmd), 0);
        #1 rst_n = 1'b1;

        // Directed transmit pairs: positive, negative, none, reserved code
        tx_set_bit = 4'd9;
        tx_frame(2'b01, 2); tx_frame(2'b10, 2);   // R2: 2'b10 at second tick ignored
        tx_frame(2'b10, 2); tx_frame(2'b01, 2);
        tx_set_bit = 4'd5;
        tx_frame(2'b10, 1); tx_frame(2'b00, 1);
        tx_frame(2'b00, 1); tx_frame(2'b10, 1);
        tx_frame(2'b11, 1); tx_frame(2'b01, 1);   // R1: reserved code acts as none

        // Directed receive pairs with single-bit errors (R4)
        rx_set_bit = 4'd9;
        rx_put(1, 3'b111); rx_put(0, 3'b110);     // positive
        rx_set_bit = 4'd5;
        rx_put(1, 3'b001); rx_put(0, 3'b000);     // negative
        rx_put(1, 3'b101); rx_put(0, 3'b010);     // none
        rx_put(1, 3'b000); rx_put(0, 3'b111);     // R6 invalid pair
        rx_put(0, 3'b111);                        // R7 orphan second word
        rx_put(1, 3'b011);                        // R5 clears

        // Random frames
        for (int f = 0; f < 800; f++) begin
            int idle;
            idle = $urandom_range(0, 3);
            frame_tick  = 1'b1;
            tx_decision = 2'($urandom_range(0, 3));
            rx_strobe   = 1'b1;
            rx_first    = ($urandom_range(0, 9) == 0) ? f[0] : !f[0];
            rx_word     = 3'($urandom_range(0, 7));
            tx_set_bit  = 4'($urandom_range(0, 12));
            rx_set_bit  = 4'($urandom_range(0, 12));
            step();
            for (int i = 0; i < idle; i++) begin
                tx_decision = 2'($urandom_range(0, 3));
                rx_word     = 3'($urandom_range(0, 7));
                tx_set_bit  = 4'($urandom_range(0, 12));
                rx_set_bit  = 4'($urandom_range(0, 12));
                step();
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule